// File: doc/BRIEF.md
# Page Migration Counter and Poison Guard

This block sits beside the directory at the home node of one page. It keeps one saturating access counter per node. On each accepted access to a line that is not poisoned, it increments the requester's counter. It then compares the new value with the home node's counter. When the requester leads by more than a programmable margin, it raises a one-cycle migration interrupt that names the requester.

Once software decides to move the page, it poisons every line of the page with a single pulse. While the page is poisoned, an access is answered with an error flag and the requester's node number is put in a small FIFO of waiting nodes. When the FIFO is full, the block stops accepting accesses. A completion pulse clears all poison, zeroes every counter and releases the waiting nodes one per cycle, oldest first.

Top module: `page_migrate_guard`

## Requirements
- R1: After reset, `acc_ready` is 1 and `resp_valid`, `resp_err`, `mig_irq` and `release_valid` are 0. All counters are zero and no line is poisoned.
- R2: An access accepted on a clock edge (`acc_valid` and `acc_ready` both high) produces `resp_valid`=1 one cycle later. For a line that is not poisoned, `resp_err`=0.
- R3: Each accepted access to an unpoisoned line raises the requester's 12-bit counter by one. The counter holds at 4095 and does not wrap.
- R4: One cycle after such an access, `mig_irq` pulses with `mig_target` equal to the requester. This happens when the requester is not the home node and its updated count is strictly greater than the home count plus `threshold`.
- R5: An access by the node equal to `home_node` never raises `mig_irq`.
- R6: A `poison_all` pulse poisons every line of the page. An access to a poisoned line gives `resp_err`=1 and no interrupt.
- R7: Each poisoned access pushes the requester's node number into an 8-entry FIFO. With 8 entries waiting, `acc_ready` is 0 and a presented access is not accepted (no response follows).
- R8: A `mig_done` pulse clears all poison and zeroes all counters. It releases the waiting nodes in arrival order, one per cycle, on `release_valid`/`release_node`, starting the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_node | input | NODE_W | Requesting node number |
| acc_line | input | LINE_W | Line index within the page |
| acc_ready | output | 1 | Access can be accepted (pending FIFO not full) |
| home_node | input | NODE_W | Node number of the page's home |
| threshold | input | CNT_W | Lead the requester needs over the home count |
| poison_all | input | 1 | Pulse: poison every line of the page |
| mig_done | input | 1 | Pulse: migration finished |
| resp_valid | output | 1 | Response to the access of the previous cycle |
| resp_err | output | 1 | Response is a bus error (line poisoned) |
| mig_irq | output | 1 | Migration interrupt pulse |
| mig_target | output | NODE_W | Node that triggered the interrupt |
| release_valid | output | 1 | A waiting node is released this cycle |
| release_node | output | NODE_W | Released node number |

## Verification
The bench uses the default parameters: 64 nodes, 32 lines, 12-bit counters and an 8-deep pending FIFO. With 12-bit counters the saturation point is reached in about four thousand accesses, so the cycle where a wrapping counter would drop back to zero can be observed through the interrupt. The 8-deep FIFO fills after eight poisoned accesses, which exposes back-pressure and full-queue release order within a few dozen cycles. Changing `home_node` and `threshold` between phases makes the compare depend on another node's count. This also shows that the completion pulse wiped the earlier counts.

// File: rtl/mig_pkg.sv
// Package for the page migration guard.
// Holds the saturating increment shared by the counter bank.
// Assumes counters are at most 32 bits wide.
package mig_pkg;
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] maxv);
        return (v >= maxv) ? maxv : v + 32'd1;
    endfunction
endpackage

// File: rtl/mig_counter_bank.sv
// Per-node access counters with the migration compare.
// Assumes at most one update per cycle. Clear has priority over an update.
// The interrupt is registered one cycle after the update.
module mig_counter_bank #(
    parameter int NODES  = 64,
    parameter int CNT_W  = 12,
    parameter int NODE_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [NODE_W-1:0] upd_node,
    input  logic              clr,
    input  logic [NODE_W-1:0] home_node,
    input  logic [CNT_W-1:0]  threshold,
    output logic              irq,
    output logic [NODE_W-1:0] irq_node
);
    localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [NODES];
    logic [CNT_W-1:0] req_next;
    logic [CNT_W:0]   bar;
    logic             fire;

    // compute the requester's next count and the migration decision
    always_comb begin
        req_next = CNT_W'(mig_pkg::sat_inc(32'(cnt_q[upd_node]), 32'(MAXC)));
        bar      = {1'b0, cnt_q[home_node]} + {1'b0, threshold};
        fire     = upd_en && !clr && (upd_node != home_node) && ({1'b0, req_next} > bar);
    end

    for (genvar g = 0; g < NODES; g++) begin : g_cnt
        // per-node counter: clear, or saturating increment on its own update
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt_q[g] <= '0;
            else if (upd_en && upd_node == NODE_W'(g))
                cnt_q[g] <= req_next;
        end
    end

    // register the interrupt pulse and the node that caused it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            irq_node <= '0;
        end else begin
            irq <= fire;
            if (fire)
                irq_node <= upd_node;
        end
    end
endmodule

// File: rtl/mig_poison_map.sv
// One poison bit per line of the page.
// Assumes the page is poisoned as a whole. Completion has priority over poisoning.
module mig_poison_map #(
    parameter int LINES  = 32,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_all,
    input  logic              clr_all,
    input  logic [LINE_W-1:0] line,
    output logic              hit,
    output logic [LINES-1:0]  bits
);
    // hold the poison bits of every line
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all)
            bits <= '0;
        else if (set_all)
            bits <= '1;
    end

    assign hit = bits[line];
endmodule

// File: rtl/mig_pending_fifo.sv
// FIFO of node numbers waiting for a migration to finish.
// Assumes the caller never pushes when full and never pops when empty.
module mig_pending_fifo #(
    parameter int DEPTH  = 8,
    parameter int W      = 6,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_WD = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [W-1:0]      din,
    input  logic              pop,
    output logic [W-1:0]      head,
    output logic              full,
    output logic              empty,
    output logic [CNT_WD-1:0] count
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;

    // storage write, no reset needed for the data
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_q] <= din;
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (push)
                wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (pop)
                rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            count <= count + CNT_WD'(push) - CNT_WD'(pop);
        end
    end

    assign head  = mem[rd_q];
    assign full  = (count == CNT_WD'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/page_migrate_guard.sv
// Top of the page migration guard for one page at its home node.
// Counts accesses per node, raises a migration interrupt, poisons the page on
// request, queues nodes that touch poisoned lines and releases them in order.
// Assumes mig_done and poison_all are single-cycle pulses from the home's handler.
module page_migrate_guard #(
    parameter int NODES  = 64,
    parameter int LINES  = 32,
    parameter int CNT_W  = 12,
    parameter int QDEPTH = 8,
    parameter int NODE_W = $clog2(NODES),
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [NODE_W-1:0] acc_node,
    input  logic [LINE_W-1:0] acc_line,
    output logic              acc_ready,
    input  logic [NODE_W-1:0] home_node,
    input  logic [CNT_W-1:0]  threshold,
    input  logic              poison_all,
    input  logic              mig_done,
    output logic              resp_valid,
    output logic              resp_err,
    output logic              mig_irq,
    output logic [NODE_W-1:0] mig_target,
    output logic              release_valid,
    output logic [NODE_W-1:0] release_node
);
    localparam int QCW = $clog2(QDEPTH + 1);

    logic              accept, hit, push, pop, q_full, q_empty, draining;
    logic [LINES-1:0]  poison_vec;
    logic [QCW-1:0]    q_count;
    logic [NODE_W-1:0] q_head;

    assign acc_ready = !q_full;
    assign accept    = acc_valid && acc_ready;
    assign push      = accept && hit;
    assign pop       = (mig_done || draining) && !q_empty;

    mig_counter_bank #(.NODES(NODES), .CNT_W(CNT_W), .NODE_W(NODE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .upd_en(accept && !hit), .upd_node(acc_node),
        .clr(mig_done), .home_node(home_node), .threshold(threshold),
        .irq(mig_irq), .irq_node(mig_target)
    );

    mig_poison_map #(.LINES(LINES), .LINE_W(LINE_W)) u_poison (
        .clk(clk), .rst_n(rst_n), .set_all(poison_all), .clr_all(mig_done),
        .line(acc_line), .hit(hit), .bits(poison_vec)
    );

    mig_pending_fifo #(.DEPTH(QDEPTH), .W(NODE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(acc_node), .pop(pop),
        .head(q_head), .full(q_full), .empty(q_empty), .count(q_count)
    );

    // drain state: begins at completion, ends once the queue is empty
    always_ff @(posedge clk) begin
        if (!rst_n)
            draining <= 1'b0;
        else if (mig_done)
            draining <= 1'b1;
        else if (q_empty)
            draining <= 1'b0;
    end

    // registered access response and node release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid    <= 1'b0;
            resp_err      <= 1'b0;
            release_valid <= 1'b0;
            release_node  <= '0;
        end else begin
            resp_valid    <= accept;
            resp_err      <= push;
            release_valid <= pop;
            if (pop)
                release_node <= q_head;
        end
    end
endmodule

// File: rtl/mig_guard_checker.sv
// Assertion checker bound to page_migrate_guard.
// Assumes it observes the top's ports plus the poison vector and queue count.
module mig_guard_checker #(
    parameter int NODE_W = 6,
    parameter int LINES  = 32,
    parameter int QDEPTH = 8,
    parameter int QCW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic [NODE_W-1:0] home_node,
    input logic              poison_all,
    input logic              mig_done,
    input logic              resp_valid,
    input logic              resp_err,
    input logic              mig_irq,
    input logic [NODE_W-1:0] mig_target,
    input logic [LINES-1:0]  poison_vec,
    input logic [QCW-1:0]    q_count
);
    assert_resp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(acc_valid && acc_ready));

    assert_irq_clean_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mig_irq |-> (resp_valid && !resp_err));

    assert_irq_not_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mig_irq |-> (mig_target != $past(home_node)));

    assert_poison_sets_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (poison_all && !mig_done) |=> (&poison_vec));

    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == QCW'(QDEPTH)) |-> !acc_ready);

    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mig_done |=> (poison_vec == '0));
endmodule

bind page_migrate_guard mig_guard_checker #(
    .NODE_W(NODE_W), .LINES(LINES), .QDEPTH(QDEPTH), .QCW(QCW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .home_node(home_node), .poison_all(poison_all), .mig_done(mig_done),
    .resp_valid(resp_valid), .resp_err(resp_err), .mig_irq(mig_irq),
    .mig_target(mig_target), .poison_vec(poison_vec), .q_count(q_count)
);

// File: tb/tb_page_migrate_guard.sv
module tb_page_migrate_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 6;
    localparam int LW = 5;
    localparam int CW = 12;

    typedef struct packed {
        logic [NW-1:0] node;
        logic [LW-1:0] line;
        logic          irq;
    } vec_t;

    // home = 0, threshold = 2, nothing poisoned
    localparam vec_t VECS [11] = '{
        '{6'd3, 5'd1, 1'b0}, '{6'd3, 5'd2, 1'b0}, '{6'd3, 5'd3, 1'b1},
        '{6'd0, 5'd4, 1'b0}, '{6'd0, 5'd5, 1'b0},
        '{6'd4, 5'd6, 1'b0}, '{6'd4, 5'd6, 1'b0}, '{6'd4, 5'd6, 1'b0}, '{6'd4, 5'd6, 1'b0},
        '{6'd3, 5'd7, 1'b0}, '{6'd3, 5'd8, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 1'b0, poison_all = 1'b0, mig_done = 1'b0;
    logic [NW-1:0] acc_node = '0, home_node = '0;
    logic [LW-1:0] acc_line = '0;
    logic [CW-1:0] threshold = '0;
    logic acc_ready, resp_valid, resp_err, mig_irq, release_valid;
    logic [NW-1:0] mig_target, release_node;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    page_migrate_guard dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_node(acc_node),
        .acc_line(acc_line), .acc_ready(acc_ready), .home_node(home_node),
        .threshold(threshold), .poison_all(poison_all), .mig_done(mig_done),
        .resp_valid(resp_valid), .resp_err(resp_err), .mig_irq(mig_irq),
        .mig_target(mig_target), .release_valid(release_valid), .release_node(release_node)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one access: drive at a falling edge, sample after the next rising edge
    task automatic access(input int node, input int line);
        acc_node  = NW'(node);
        acc_line  = LW'(line);
        acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic pulse_poison();
        poison_all = 1'b1;
        @(negedge clk);
        poison_all = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(acc_ready == 1'b1, "R1 ready", acc_ready, 1);
        check(!resp_valid && !mig_irq && !release_valid, "R1 outputs idle",
              {resp_valid, mig_irq, release_valid}, 0);

        // vector table: R2 response, R3 counting, R4 compare, R5 home access
        home_node = 6'd0;
        threshold = 12'd2;
        foreach (VECS[i]) begin
            access(VECS[i].node, VECS[i].line);
            check(resp_valid && !resp_err, "R2 clean response", {resp_valid, resp_err}, 2);
            check(mig_irq == VECS[i].irq, "R3/R4 irq decision", mig_irq, VECS[i].irq);
            if (VECS[i].irq)
                check(mig_target == VECS[i].node, "R4 target", mig_target, VECS[i].node);
        end

        // R5: node 3 is now home, lead over itself never triggers
        home_node = 6'd3;
        threshold = 12'd0;
        access(3, 9);
        check(!mig_irq, "R5 home access", mig_irq, 0);

        // R6: poisoned page returns an error and no interrupt
        pulse_poison();
        access(9, 0);
        check(resp_valid && resp_err, "R6 error response", {resp_valid, resp_err}, 3);
        check(!mig_irq, "R6 no irq", mig_irq, 0);

        // R7: fill the pending FIFO to 8 entries
        for (int n = 10; n < 17; n++) access(n, n);
        check(acc_ready == 1'b0, "R7 full back-pressure", acc_ready, 0);
        access(30, 1);
        check(!resp_valid, "R7 access not accepted", resp_valid, 0);

        // R8: completion releases nodes 9..16 in order
        mig_done = 1'b1;
        @(negedge clk);
        mig_done = 1'b0;
        for (int k = 0; k < 8; k++) begin
            check(release_valid && release_node == NW'(9 + k), "R8 release order",
                  release_node, 9 + k);
            @(negedge clk);
        end
        check(!release_valid, "R8 release stops", release_valid, 0);

        // R8: poison cleared, counters zeroed (node 4 had 4, home 3 had 6)
        access(4, 2);
        check(resp_valid && !resp_err, "R8 poison cleared", resp_err, 0);
        check(mig_irq && mig_target == 6'd4, "R8 counters reset", mig_irq, 1);

        // R3 saturation: home 0 at zero, margin 4094, node 20 accesses
        home_node = 6'd0;
        threshold = 12'd4094;
        for (int a = 1; a <= 4100; a++) begin
            access(20, 3);
            if (a == 4094) check(!mig_irq, "R3 below limit", mig_irq, 0);
            if (a == 4095) check(mig_irq, "R3 at limit", mig_irq, 1);
            if (a == 4096) check(mig_irq, "R3 saturates", mig_irq, 1);
            if (a == 4100) check(mig_irq, "R3 stays saturated", mig_irq, 1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule